// File: doc/BRIEF.md
# Four-Level Nested Interrupt Controller

This block sits between sixteen interrupt request lines and a small microcontroller core. Software programs six 8-bit registers through a plain write/read port: two enable registers, two low-order priority registers and two high-order priority registers. Each source gets a 2-bit priority level from a pair of matching bits. The block combines the enables, the global gate and the levels, and finds the winning source. It offers that source to the core as a request with a source index and a level.

The core answers with an acknowledge, which marks the granted level as in service. It later sends a return pulse, which retires the most recent (highest) active level. Because the in-service levels are tracked, a handler can be preempted only by a request of strictly higher level, and interrupts nest up to four deep. Within one level the lowest source index always wins.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset every register reads 0, no level is in service (`active_lvls` = 0) and `irq_valid` is 0.
- R2: Register map by `reg_addr`: 0 primary enable, 1 secondary enable, 2 primary level-low, 3 secondary level-low, 4 primary level-high, 5 secondary level-high. A write takes effect at the clock edge when `reg_we` is 1. `reg_rdata` shows the addressed register combinationally. Addresses 6 and 7 read 0, and writes to them change nothing.
- R3: Bit 7 of the primary enable register is the global gate. While it is 0, `irq_valid` stays 0 whatever the other bits and requests are.
- R4: Source i (i in 0..6) is gated by primary enable bit i, and source i (i in 8..15) by secondary enable bit i-8, with 1 allowing the source. Request line 7 shares its bit with the global gate and is never taken.
- R5: The level of source i is {high bit, low bit}. The bits are taken from bit i mod 8 of the level-high and level-low registers of its half (primary for i < 8).
- R6: Among eligible pending sources, the one with the highest level is offered. `irq_lvl` shows its level.
- R7: Among eligible sources of equal level, the lowest index is offered on `irq_src`.
- R8: A request is offered only if its level is strictly above the highest in-service level. While level 3 is in service, nothing is offered.
- R9: `irq_ack` while `irq_valid` is 1 sets the `active_lvls` bit of the offered level at the next edge. `irq_ack` while `irq_valid` is 0 has no effect.
- R10: `irq_ret` clears the highest set bit of `active_lvls`, and has no effect when none is set. When `irq_ret` and a valid acknowledge arrive in the same cycle, the clear is applied first and the granted bit is set afterwards.
- R11: While `irq_valid` is 0, `irq_src` and `irq_lvl` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| irq_req | input | 16 | Pending request per source |
| irq_ack | input | 1 | Core accepts the offered request |
| irq_ret | input | 1 | Core returns from the current handler |
| irq_valid | output | 1 | A request is offered to the core |
| irq_src | output | 4 | Index of the offered source |
| irq_lvl | output | 2 | Level of the offered source |
| active_lvls | output | 4 | In-service levels, one bit per level |

## Verification
The assertions assume a well-behaved core. It acknowledges only what is currently offered, and it sends a return pulse at most once per cycle. They also assume request lines that change only between clock edges. Nothing in the assertions assumes that the in-service vector is non-empty when a return arrives, so the stimulus deliberately sends returns on an empty vector and acknowledges with no offer present. The randomized phase drives all inputs at the falling edge. It mixes register writes, including to the two unused addresses, with random request masks and random acknowledge and return pulses. The return rate is kept high enough that the in-service vector keeps draining and refilling.

// File: rtl/nest_irq_pkg.sv
// Shared sizes for the nested interrupt controller.
// Assumes sixteen sources split into two halves of eight.
package nest_irq_pkg;
    localparam int NSRC   = 16;
    localparam int DW     = 8;
    localparam int AW     = 3;
    localparam int NLVL   = 4;
    localparam int LW     = $clog2(NLVL);
    localparam int IW     = $clog2(NSRC);
    localparam int NREG   = 6;
    localparam int GE_BIT = 7;
endpackage

// File: rtl/irq_cfg_regs.sv
// Software register file: two enable, two level-low, two level-high registers.
// Produces the gated per-source enable vector and the flattened per-source level.
// Assumes NSRC == 2*DW; the global gate sits at bit GE_BIT of register 0.
module irq_cfg_regs
    import nest_irq_pkg::*;
#(
    parameter int P_NSRC = NSRC,
    parameter int P_DW   = DW,
    parameter int P_AW   = AW,
    parameter int P_LW   = LW
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [P_AW-1:0]          addr,
    input  logic [P_DW-1:0]          wdata,
    output logic [P_DW-1:0]          rdata,
    output logic                     glob_en,
    output logic [P_NSRC-1:0]        src_en,
    output logic [P_NSRC*P_LW-1:0]   src_lvl
);
    localparam int HALF = P_NSRC / 2;

    logic [P_DW-1:0] regs [NREG];

    // Register update on writes to a valid address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NREG; k++) regs[k] <= '0;
        end else if (we && (int'(addr) < NREG)) begin
            regs[addr] <= wdata;
        end
    end

    // Read mux; unused addresses return zero.
    always_comb begin
        rdata = '0;
        if (int'(addr) < NREG) rdata = regs[addr];
    end

    assign glob_en = regs[0][GE_BIT];

    // Per-source enable and level mapping.
    for (genvar i = 0; i < P_NSRC; i++) begin : g_src
        localparam int HF  = i / HALF;
        localparam int BIT = i % HALF;
        if (HF == 0 && BIT == GE_BIT) begin : g_dead
            assign src_en[i] = 1'b0;
        end else begin : g_live
            assign src_en[i] = regs[HF][BIT];
        end
        assign src_lvl[i*P_LW +: P_LW] = {regs[4+HF][BIT], regs[2+HF][BIT]};
    end

    // R2
    unused_addr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && int'(addr) >= NREG) |=> (regs[0] == $past(regs[0]) && regs[5] == $past(regs[5])));
endmodule

// File: rtl/irq_pick.sv
// Arbiter: finds the highest-level pending source, lowest index on ties,
// and offers it only if it lies above the in-service ceiling.
// Assumes pend is already masked by the enables and the global gate.
module irq_pick
    import nest_irq_pkg::*;
#(
    parameter int P_NSRC = NSRC,
    parameter int P_LW   = LW,
    parameter int P_IW   = IW
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [P_NSRC-1:0]        pend,
    input  logic [P_NSRC*P_LW-1:0]   src_lvl,
    input  logic                     svc_any,
    input  logic [P_LW-1:0]          svc_top,
    output logic                     valid,
    output logic [P_IW-1:0]          src,
    output logic [P_LW-1:0]          lvl
);
    logic             found;
    logic [P_IW-1:0]  best_i;
    logic [P_LW-1:0]  best_l;

    // Scan from the top index down so equal levels resolve to the lowest index.
    always_comb begin
        found  = 1'b0;
        best_i = '0;
        best_l = '0;
        for (int i = P_NSRC - 1; i >= 0; i--) begin
            if (pend[i] && (!found || src_lvl[i*P_LW +: P_LW] >= best_l)) begin
                found  = 1'b1;
                best_i = P_IW'(i);
                best_l = src_lvl[i*P_LW +: P_LW];
            end
        end
    end

    // Gate the winner against the in-service ceiling.
    always_comb begin
        valid = found && (!svc_any || best_l > svc_top);
        src   = valid ? best_i : '0;
        lvl   = valid ? best_l : '0;
    end

    // R4
    offer_is_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> pend[src]);
    // R8
    preempt_strict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && svc_any) |-> (lvl > svc_top));
    // R11
    idle_outputs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (src == '0 && lvl == '0));
endmodule

// File: rtl/irq_svc_track.sv
// In-service tracker: one bit per level; a grant sets its level's bit,
// a return clears the highest set bit (applied before the grant).
// Assumes grant is only raised for an offered request.
module irq_svc_track
    import nest_irq_pkg::*;
#(
    parameter int P_NLVL = NLVL,
    parameter int P_LW   = LW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               grant,
    input  logic [P_LW-1:0]    grant_lvl,
    input  logic               retire,
    output logic [P_NLVL-1:0]  active,
    output logic               any,
    output logic [P_LW-1:0]    top
);
    logic [P_NLVL-1:0] top_hot;
    logic [P_NLVL-1:0] set_hot;

    // Highest active level and its one-hot mask.
    always_comb begin
        top     = '0;
        top_hot = '0;
        for (int l = 0; l < P_NLVL; l++) begin
            if (active[l]) begin
                top     = P_LW'(l);
                top_hot = P_NLVL'(1) << l;
            end
        end
        set_hot = grant ? (P_NLVL'(1) << grant_lvl) : '0;
    end

    assign any = |active;

    // Clear the retired level first, then set the granted one.
    always_ff @(posedge clk) begin
        if (!rst_n) active <= '0;
        else        active <= (retire ? (active & ~top_hot) : active) | set_hot;
    end

    // R9
    grant_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> active[$past(grant_lvl)]);
    // R10
    retire_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && !grant && active == '0) |=> active == '0);
    // R10
    retire_drops_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && !grant && active != '0) |=> $countones(active) == $countones($past(active)) - 1);
endmodule

// File: rtl/nest_irq_ctrl.sv
// Top of the four-level nested interrupt controller.
// Joins the register file, the arbiter and the in-service tracker.
// Assumes the core acknowledges only while irq_valid is high (others are ignored).
module nest_irq_ctrl
    import nest_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic [NSRC-1:0]   irq_req,
    input  logic              irq_ack,
    input  logic              irq_ret,
    output logic              irq_valid,
    output logic [IW-1:0]     irq_src,
    output logic [LW-1:0]     irq_lvl,
    output logic [NLVL-1:0]   active_lvls
);
    logic                  glob_en;
    logic [NSRC-1:0]       src_en;
    logic [NSRC*LW-1:0]    src_lvl;
    logic [NSRC-1:0]       pend;
    logic                  svc_any;
    logic [LW-1:0]         svc_top;
    logic                  grant;

    irq_cfg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .glob_en (glob_en),
        .src_en  (src_en),
        .src_lvl (src_lvl)
    );

    // Mask requests with per-source enables and the global gate.
    always_comb pend = glob_en ? (irq_req & src_en) : '0;

    irq_pick u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend    (pend),
        .src_lvl (src_lvl),
        .svc_any (svc_any),
        .svc_top (svc_top),
        .valid   (irq_valid),
        .src     (irq_src),
        .lvl     (irq_lvl)
    );

    // Only an acknowledge of a live offer counts as a grant.
    always_comb grant = irq_ack && irq_valid;

    irq_svc_track u_svc (
        .clk       (clk),
        .rst_n     (rst_n),
        .grant     (grant),
        .grant_lvl (irq_lvl),
        .retire    (irq_ret),
        .active    (active_lvls),
        .any       (svc_any),
        .top       (svc_top)
    );

    // R3
    global_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata_ge_q |-> !irq_valid);
    // R8
    top_level_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active_lvls[NLVL-1] |-> !irq_valid);
    // R4
    line7_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_src != IW'(GE_BIT)));

    logic reg_rdata_ge_q;
    assign reg_rdata_ge_q = glob_en;
endmodule

// File: tb/nest_irq_ctrl_bench.sv
// Self-checking bench: directed corners then constrained random traffic,
// compared against a bench-side reference model.
module nest_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [15:0] irq_req = '0;
    logic        irq_ack = 1'b0;
    logic        irq_ret = 1'b0;
    logic        irq_valid;
    logic [3:0]  irq_src;
    logic [1:0]  irq_lvl;
    logic [3:0]  active_lvls;

    int checks = 0;
    int fails  = 0;
    logic [7:0] m_r [8];
    logic [3:0] m_isr;

    always #2 clk = ~clk;

    nest_irq_ctrl u_nest_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
        .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_valid(irq_valid),
        .irq_src(irq_src), .irq_lvl(irq_lvl), .active_lvls(active_lvls)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference winner from the model registers and in-service vector.
    function automatic void ref_pick(input logic [15:0] req, output bit v, output int s, output int l);
        bit found = 0;
        int bi = 0, bl = 0, top = -1;
        for (int i = 0; i < 16; i++) begin
            int h = i / 8, b = i % 8;
            bit en = (h == 0) ? (b != 7 && m_r[0][b]) : m_r[1][b];
            int lv = {m_r[4+h][b], m_r[2+h][b]};
            if (req[i] && en && (!found || lv > bl)) begin
                found = 1; bi = i; bl = lv;
            end
        end
        for (int k = 0; k < 4; k++) if (m_isr[k]) top = k;
        v = found && m_r[0][7] && (bl > top);
        s = v ? bi : 0;
        l = v ? bl : 0;
    endfunction

    task automatic wr(input int a, input logic [7:0] d);
        reg_we = 1; reg_addr = 3'(a); reg_wdata = d;
        @(posedge clk);
        if (a < 6) m_r[a] = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(input int a, input string req);
        logic [7:0] e;
        reg_addr = 3'(a);
        #1;
        e = (a < 6) ? m_r[a] : 8'h00;
        chk(reg_rdata == e, req, "rdata", int'(reg_rdata), int'(e));
    endtask

    // One cycle of interrupt traffic: check offer, clock, update model.
    task automatic step(input logic [15:0] rq, input bit ack, input bit ret, input string req);
        bit v; int s, l;
        irq_req = rq; irq_ack = ack; irq_ret = ret;
        #1;
        ref_pick(rq, v, s, l);
        chk(irq_valid == v, req, "irq_valid", int'(irq_valid), int'(v));
        chk(int'(irq_src) == s, req, "irq_src", int'(irq_src), s);
        chk(int'(irq_lvl) == l, req, "irq_lvl", int'(irq_lvl), l);
        chk(active_lvls == m_isr, req, "active_lvls", int'(active_lvls), int'(m_isr));
        @(posedge clk);
        if (ret) begin
            for (int k = 3; k >= 0; k--) if (m_isr[k]) begin m_isr[k] = 0; break; end
        end
        if (ack && v) m_isr[l] = 1;
        @(negedge clk);
        irq_ack = 0; irq_ret = 0;
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int k = 0; k < 8; k++) m_r[k] = 0;
        m_isr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        for (int a = 0; a < 8; a++) rd(a, "R1");
        step(16'hFFFF, 0, 0, "R1");
        // R2 map, unused addresses
        wr(6, 8'hAA); wr(7, 8'h55); rd(6, "R2"); rd(7, "R2");
        wr(3, 8'h5A); rd(3, "R2"); wr(3, 8'h00); rd(3, "R2");
        // R3 global gate off
        wr(0, 8'h7F); wr(1, 8'hFF);
        step(16'hFFFF, 0, 0, "R3");
        wr(0, 8'hFF);
        step(16'hFFFF, 0, 0, "R7");
        step(16'h0080, 0, 0, "R4");
        step(16'h0100, 0, 0, "R4");
        wr(0, 8'hFE);
        step(16'h0001, 0, 0, "R4");
        wr(0, 8'hFF);
        // R5/R6 levels
        wr(3, 8'h01);
        step(16'h0101, 0, 0, "R6");
        wr(4, 8'h08);
        step(16'h0109, 0, 0, "R5");
        step(16'h0109, 1, 0, "R9");
        step(16'h0109, 0, 0, "R8");
        wr(4, 8'h28); wr(2, 8'h20);
        step(16'h0028, 0, 0, "R8");
        step(16'h0028, 1, 0, "R9");
        step(16'hFFFF, 0, 0, "R8");
        step(16'h0000, 0, 1, "R10");
        step(16'h0000, 0, 1, "R10");
        step(16'h0000, 0, 1, "R10");
        step(16'h0000, 1, 0, "R9");
        step(16'h0000, 0, 0, "R11");
        // R10 simultaneous retire and grant
        step(16'h0008, 1, 0, "R9");
        step(16'h0020, 1, 1, "R10");
        step(16'h0000, 0, 1, "R10");
        // Random phase
        for (int n = 0; n < 4000; n++) begin
            int r = int'($urandom_range(0, 99));
            if (r < 8) begin
                int a = int'($urandom_range(0, 7));
                logic [7:0] d = 8'($urandom);
                if (a == 0 && $urandom_range(0, 3) != 0) d[7] = 1'b1;
                wr(a, d);
            end else if (r < 12) begin
                rd(int'($urandom_range(0, 7)), "R2");
            end else begin
                step(16'($urandom), 1'($urandom_range(0, 1)),
                     $urandom_range(0, 3) == 0, "R6");
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule